// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block is the hardware half of a transmit DMA. Software fills a small on-block descriptor ring through a write port, then moves a last-descriptor pointer forward. The engine walks the ring from its current index up to that pointer. For each descriptor it turns the byte count into a stream of read requests of at most one beat each, and it retires the descriptor when the last beat is accepted.

Software tracks progress through the current-descriptor index: every slot before it is finished and may be reused. A two-bit state field reports whether the engine is off, working, drained or held. Suspend and disable never cut a descriptor short. Each waits for the descriptor in flight to retire, and the state field shows the difference between the two holds. A descriptor can ask for a one-cycle completion pulse, and a loopback control bit travels with every request of the descriptors fetched while it is set.

Top module: `txring_dma`

## Requirements
- R1: In reset the state field is 0, the current index is 0, and neither a request nor a completion pulse is raised.
- R2: A descriptor word holds the byte count in bits [BCW-1:0]. The engine emits that count as beats of min(remaining, BEAT_BYTES) bytes, in order. A beat is offered until it is accepted (rq_valid and rq_ready high at a clock edge), and its fields stay unchanged while it waits.
- R3: Bit BCW is start-of-frame and bit BCW+1 is end-of-frame. rq_sof is high only on the first beat of a descriptor with start-of-frame set, and rq_eof only on the final beat of one with end-of-frame set.
- R4: A pointer write with lp_wr starts the engine. It fetches descriptors while its current index differs from the pointer, and it stops when the two are equal.
- R5: Retiring a descriptor moves the current index to the next slot modulo DEPTH. If bit BCW+3 (end-of-table) is set, the index goes to 0 instead.
- R6: Retiring a descriptor with bit BCW+2 (completion request) set raises done_pulse for exactly one cycle, in the cycle after the retiring edge.
- R7: While ctl_suspend is high, the descriptor in flight completes and no new one is fetched. The state then reads 3 (held) if work is pending, or 2 if not. Clearing suspend resumes fetching.
- R8: Clearing ctl_enable lets the descriptor in flight finish with the state at 1. After that the state reads 0 and no further descriptor is fetched until enable returns.
- R9: With the engine enabled and not suspended, nothing in flight and the current index equal to the pointer, the state reads 2 and no request is raised.
- R10: The loopback bit is captured when a descriptor is fetched and is driven on rq_loop for every beat of that descriptor.
- R11: A descriptor with byte count 0 retires without raising any request.
- R12: State codes are 0 disabled, 1 active (a descriptor is in flight or about to be fetched), 2 idle and 3 stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | IW | Ring slot being written |
| dw_word | input | BCW+4 | Descriptor word: count, start, end, completion request, end-of-table |
| lp_wr | input | 1 | Last-descriptor pointer write strobe |
| lp_val | input | IW | New last-descriptor pointer |
| ctl_enable | input | 1 | Engine enable |
| ctl_suspend | input | 1 | Hold at the next descriptor boundary |
| ctl_loop | input | 1 | Loopback mark for descriptors fetched while set |
| rq_valid | output | 1 | Read request offered |
| rq_ready | input | 1 | Read request accepted |
| rq_bytes | output | BBW | Bytes in this beat |
| rq_sof | output | 1 | First beat of a frame |
| rq_eof | output | 1 | Last beat of a frame |
| rq_loop | output | 1 | Loopback mark of the descriptor |
| st_state | output | 2 | Engine state code |
| st_cur_idx | output | IW | Current descriptor index |
| done_pulse | output | 1 | Completion pulse |

## Verification
Two kinds of event can land in the same cycle as the retirement of a descriptor. One is a pointer write that extends the ring. The other is suspend or disable changing. The bench provokes both in random batches: it moves the pointer a second time while the engine is still draining, and it toggles suspend on random cycles while random back-pressure shifts the retirement edges. A scoreboard judges each accepted beat against the beats the bench predicts from the descriptors. After each batch the bench also compares the final index and the completion count with its own model.

// File: rtl/txr_pkg.sv
// Shared types for the transmit descriptor ring engine.
// Assumes: state codes are visible to software and must stay fixed.
package txr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_IDLE = 2'd2,
        ST_HALT = 2'd3
    } txr_state_e;
endpackage

// File: rtl/txr_desc_mem.sv
// Descriptor ring storage: one write port for software, one
// asynchronous read port for the fetch logic.
// Assumes: software never rewrites a slot that is in flight.
module txr_desc_mem #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_word,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DW-1:0]            rd_word
);
    logic [DW-1:0] slots [DEPTH];

    // Store a descriptor written by software
    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_word;
    end

    // Present the slot at the current index
    assign rd_word = slots[rd_idx];
endmodule

// File: rtl/txr_status.sv
// Holds the last-descriptor pointer and derives the state code.
// Assumes: the pointer is written only with lp_wr.
module txr_status #(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lp_wr,
    input  logic [$clog2(DEPTH)-1:0] lp_val,
    input  logic                     enable,
    input  logic                     suspend,
    input  logic                     busy,
    input  logic [$clog2(DEPTH)-1:0] cur_idx,
    output logic [$clog2(DEPTH)-1:0] last_idx,
    output logic [1:0]               state
);
    import txr_pkg::*;
    localparam int IW = $clog2(DEPTH);

    logic       pending;
    txr_state_e st;

    // Capture the pointer software advances
    always_ff @(posedge clk) begin
        if (!rst_n)     last_idx <= '0;
        else if (lp_wr) last_idx <= lp_val;
    end

    assign pending = (cur_idx != last_idx);

    // Encode the engine state; a transfer in flight always reads active
    always_comb begin
        if (busy)          st = ST_RUN;
        else if (!enable)  st = ST_OFF;
        else if (suspend)  st = pending ? ST_HALT : ST_IDLE;
        else if (pending)  st = ST_RUN;
        else               st = ST_IDLE;
    end

    assign state = st;
endmodule

// File: rtl/txr_engine.sv
// Fetch and beat engine: loads one descriptor at a time, splits its
// byte count into beats and retires it on the last accepted beat.
// Assumes: DEPTH is a power of two so index arithmetic wraps naturally.
module txr_engine #(
    parameter int DEPTH      = 8,
    parameter int BCW        = 12,
    parameter int BEAT_BYTES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             enable,
    input  logic                             suspend,
    input  logic                             loop_in,
    input  logic [$clog2(DEPTH)-1:0]         last_idx,
    input  logic [BCW+3:0]                   desc_word,
    output logic [$clog2(DEPTH)-1:0]         cur_idx,
    output logic                             busy,
    output logic                             rq_valid,
    input  logic                             rq_ready,
    output logic [$clog2(BEAT_BYTES+1)-1:0]  rq_bytes,
    output logic                             rq_sof,
    output logic                             rq_eof,
    output logic                             rq_loop,
    output logic                             done
);
    localparam int IW    = $clog2(DEPTH);
    localparam int BBW   = $clog2(BEAT_BYTES + 1);
    localparam int B_SOF = BCW;
    localparam int B_EOF = BCW + 1;
    localparam int B_IOC = BCW + 2;
    localparam int B_EOT = BCW + 3;

    logic [BCW-1:0] rem;
    logic           first;
    logic           d_sof, d_eof, d_ioc, d_eot, d_loop;
    logic [BBW-1:0] beat;
    logic           last_beat;
    logic           hs, fetch, retire;

    // Beat size: a one-byte beat needs no comparator
    generate
        if (BEAT_BYTES == 1) begin : g_unit
            assign beat      = BBW'(1);
            assign last_beat = (rem <= BCW'(1));
        end else begin : g_wide
            assign beat      = (rem > BCW'(BEAT_BYTES)) ? BBW'(BEAT_BYTES) : BBW'(rem);
            assign last_beat = (rem <= BCW'(BEAT_BYTES));
        end
    endgenerate

    assign hs     = rq_valid && rq_ready;
    assign fetch  = !busy && enable && !suspend && (cur_idx != last_idx);
    assign retire = busy && ((rem == '0) || (hs && last_beat));

    // Load, step and retire descriptors; raise completion a cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rem     <= '0;
            first   <= 1'b0;
            d_sof   <= 1'b0;
            d_eof   <= 1'b0;
            d_ioc   <= 1'b0;
            d_eot   <= 1'b0;
            d_loop  <= 1'b0;
            cur_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= retire && d_ioc;
            if (fetch) begin
                busy   <= 1'b1;
                rem    <= desc_word[BCW-1:0];
                first  <= 1'b1;
                d_sof  <= desc_word[B_SOF];
                d_eof  <= desc_word[B_EOF];
                d_ioc  <= desc_word[B_IOC];
                d_eot  <= desc_word[B_EOT];
                d_loop <= loop_in;
            end else if (retire) begin
                busy    <= 1'b0;
                cur_idx <= d_eot ? '0 : cur_idx + IW'(1);
            end else if (hs) begin
                rem   <= rem - BCW'(beat);
                first <= 1'b0;
            end
        end
    end

    // Request outputs for the beat being offered
    assign rq_valid = busy && (rem != '0);
    assign rq_bytes = beat;
    assign rq_sof   = d_sof && first;
    assign rq_eof   = d_eof && last_beat;
    assign rq_loop  = d_loop;
endmodule

// File: rtl/txring_dma.sv
// Top of the transmit descriptor ring engine: ring storage, fetch and
// beat engine, pointer register and state encoder.
// Assumes: software keeps at most DEPTH-1 descriptors pending.
module txring_dma #(
    parameter int DEPTH      = 8,
    parameter int BCW        = 12,
    parameter int BEAT_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            dw_en,
    input  logic [$clog2(DEPTH)-1:0]        dw_idx,
    input  logic [BCW+3:0]                  dw_word,
    input  logic                            lp_wr,
    input  logic [$clog2(DEPTH)-1:0]        lp_val,
    input  logic                            ctl_enable,
    input  logic                            ctl_suspend,
    input  logic                            ctl_loop,
    output logic                            rq_valid,
    input  logic                            rq_ready,
    output logic [$clog2(BEAT_BYTES+1)-1:0] rq_bytes,
    output logic                            rq_sof,
    output logic                            rq_eof,
    output logic                            rq_loop,
    output logic [1:0]                      st_state,
    output logic [$clog2(DEPTH)-1:0]        st_cur_idx,
    output logic                            done_pulse
);
    localparam int IW = $clog2(DEPTH);
    localparam int DW = BCW + 4;

    logic [DW-1:0] cur_word;
    logic [IW-1:0] last_idx;
    logic          busy;

    txr_desc_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
        .clk(clk), .wr_en(dw_en), .wr_idx(dw_idx), .wr_word(dw_word),
        .rd_idx(st_cur_idx), .rd_word(cur_word)
    );

    txr_engine #(.DEPTH(DEPTH), .BCW(BCW), .BEAT_BYTES(BEAT_BYTES)) i_eng (
        .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .suspend(ctl_suspend),
        .loop_in(ctl_loop), .last_idx(last_idx), .desc_word(cur_word),
        .cur_idx(st_cur_idx), .busy(busy), .rq_valid(rq_valid),
        .rq_ready(rq_ready), .rq_bytes(rq_bytes), .rq_sof(rq_sof),
        .rq_eof(rq_eof), .rq_loop(rq_loop), .done(done_pulse)
    );

    txr_status #(.DEPTH(DEPTH)) i_stat (
        .clk(clk), .rst_n(rst_n), .lp_wr(lp_wr), .lp_val(lp_val),
        .enable(ctl_enable), .suspend(ctl_suspend), .busy(busy),
        .cur_idx(st_cur_idx), .last_idx(last_idx), .state(st_state)
    );
endmodule

// File: rtl/txring_dma_chk.sv
// Protocol and state checks on the ring engine's ports, bound to the top.
// Assumes: reset is applied from time zero.
module txring_dma_chk #(
    parameter int DEPTH      = 8,
    parameter int BEAT_BYTES = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            rq_valid,
    input logic                            rq_ready,
    input logic [$clog2(BEAT_BYTES+1)-1:0] rq_bytes,
    input logic                            rq_sof,
    input logic                            rq_eof,
    input logic [1:0]                      st_state,
    input logic [$clog2(DEPTH)-1:0]        st_cur_idx,
    input logic                            done_pulse
);
    localparam int IW  = $clog2(DEPTH);
    localparam int BBW = $clog2(BEAT_BYTES + 1);

    // R2: every offered beat carries between 1 and BEAT_BYTES bytes
    a_r2_beat_size: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> (rq_bytes != '0) && (rq_bytes <= BBW'(BEAT_BYTES)));

    // R2: a stalled beat stays offered and unchanged
    a_r2_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && !rq_ready) |=> rq_valid && $stable(rq_bytes)
                                    && $stable(rq_sof) && $stable(rq_eof));

    // R8: requests appear only while the state reads active
    a_r8_req_when_active: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid |-> (st_state == 2'd1));

    // R5: the index only steps by one or returns to zero
    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_cur_idx) |-> (st_cur_idx == $past(st_cur_idx) + IW'(1))
                                 || (st_cur_idx == '0));

    // R6: completion is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R9: an idle engine offers nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_state == 2'd2) |-> !rq_valid);
endmodule

bind txring_dma txring_dma_chk #(.DEPTH(DEPTH), .BEAT_BYTES(BEAT_BYTES)) i_chk (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_bytes(rq_bytes), .rq_sof(rq_sof), .rq_eof(rq_eof),
    .st_state(st_state), .st_cur_idx(st_cur_idx), .done_pulse(done_pulse)
);

// File: tb/test_txring_dma.sv
// Self-checking bench: directed corner cases, then seeded random batches
// scored against a bench-side model of the descriptor ring.
module test_txring_dma;
    localparam int DEPTH = 8;
    localparam int BCW   = 12;
    localparam int BEAT  = 4;
    localparam int IW    = 3;
    localparam int DW    = 16;
    localparam int BBW   = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dw_en = 1'b0, lp_wr = 1'b0;
    logic [IW-1:0] dw_idx = '0, lp_val = '0;
    logic [DW-1:0] dw_word = '0;
    logic ctl_enable = 1'b0, ctl_suspend = 1'b0, ctl_loop = 1'b0;
    logic rq_ready = 1'b0;
    logic rq_valid, rq_sof, rq_eof, rq_loop, done_pulse;
    logic [BBW-1:0] rq_bytes;
    logic [1:0] st_state;
    logic [IW-1:0] st_cur_idx;

    int nchk = 0, nfail = 0;
    int rdy_mode = 0;
    logic rdy_force = 1'b0;
    int done_seen = 0, exp_done = 0, beats_seen = 0, loop_beats = 0;
    int cycles = 0;
    bit finished = 0;
    logic [DW-1:0] bmem [DEPTH];
    logic [IW-1:0] mcur = '0;
    int expq[$];

    txring_dma #(.DEPTH(DEPTH), .BCW(BCW), .BEAT_BYTES(BEAT)) i_txring_dma (.*);

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(0, "watchdog", cycles, 150000);
                finish_run();
            end
        end
    end

    // Ready driver: forced level or random back-pressure
    initial begin
        forever begin
            @(posedge clk);
            #2;
            rq_ready = (rdy_mode == 0) ? rdy_force : (($urandom % 4) != 0);
        end
    end

    // Scoreboard for accepted beats (R2, R3, R10) and completion pulses (R6)
    always @(negedge clk) begin
        if (rst_n && rq_valid && rq_ready) begin
            int act;
            beats_seen++;
            if (rq_loop) loop_beats++;
            act = int'(rq_bytes) * 8 + int'(rq_sof) * 4 + int'(rq_eof) * 2 + int'(rq_loop);
            if (expq.size() == 0) check(0, "R2 unexpected beat", act, -1);
            else begin
                int e;
                e = expq.pop_front();
                check(act == e, "R2/R3/R10 beat", act, e);
            end
        end
        if (rst_n && done_pulse) done_seen++;
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [DW-1:0] mkword(int cnt, bit sof, bit eof, bit ioc, bit eot);
        return {eot, ioc, eof, sof, BCW'(cnt)};
    endfunction

    task automatic wdesc(input logic [IW-1:0] idx, input logic [DW-1:0] w);
        dw_en = 1'b1; dw_idx = idx; dw_word = w;
        bmem[idx] = w;
        tick();
        dw_en = 1'b0;
    endtask

    // Predict the beats of one descriptor from the requirement text
    task automatic push_desc(input logic [DW-1:0] w, input bit lp);
        int rem = int'(w[BCW-1:0]);
        bit first = 1;
        while (rem > 0) begin
            int b = (rem > BEAT) ? BEAT : rem;
            expq.push_back(b * 8 + int'(w[BCW] && first) * 4 + int'(w[BCW+1] && rem <= BEAT) * 2 + int'(lp));
            rem -= b;
            first = 0;
        end
        if (w[BCW+2]) exp_done++;
    endtask

    task automatic setlp(input logic [IW-1:0] v);
        lp_wr = 1'b1; lp_val = v;
        tick();
        lp_wr = 1'b0;
        while (mcur != v) begin
            push_desc(bmem[mcur], ctl_loop);
            mcur = bmem[mcur][BCW+3] ? '0 : mcur + IW'(1);
        end
    endtask

    task automatic wait_state(input logic [1:0] code, input int maxc, input string req);
        int n = 0;
        @(negedge clk);
        while (st_state != code && n < maxc) begin
            @(negedge clk);
            n++;
        end
        check(st_state == code, req, int'(st_state), int'(code));
    endtask

    initial begin
        int b0;
        void'($urandom(32'h5eed_1234));
        // R1 / R12: reset state
        repeat (3) tick();
        @(negedge clk);
        check(st_state == 2'd0, "R1 R12 reset state", int'(st_state), 0);
        check(st_cur_idx == '0, "R1 reset index", int'(st_cur_idx), 0);
        check(!rq_valid && !done_pulse, "R1 quiet outputs", int'(rq_valid), 0);
        tick();
        rst_n = 1'b1;

        // R9: enabled with empty ring reads idle
        ctl_enable = 1'b1;
        tick();
        @(negedge clk);
        check(st_state == 2'd2, "R9 empty idle", int'(st_state), 2);

        // R7: suspend lets the descriptor in flight finish, then holds
        rdy_force = 1'b0;
        wdesc(0, mkword(10, 1, 1, 1, 0));
        wdesc(1, mkword(5, 1, 1, 0, 0));
        setlp(2);
        tick();
        ctl_suspend = 1'b1;
        @(negedge clk);
        check(st_state == 2'd1, "R7 active while in flight", int'(st_state), 1);
        rdy_force = 1'b1;
        wait_state(2'd3, 50, "R7 stopped after boundary");
        check(st_cur_idx == 1, "R7 one descriptor retired", int'(st_cur_idx), 1);
        repeat (4) @(negedge clk);
        check(st_cur_idx == 1 && !rq_valid, "R7 no fetch while suspended", int'(st_cur_idx), 1);
        #2 ctl_suspend = 1'b0;
        wait_state(2'd2, 50, "R7 resume drains");
        check(st_cur_idx == 2, "R4 stop at pointer", int'(st_cur_idx), 2);

        // R8: disable waits for the descriptor in flight
        rdy_force = 1'b0;
        tick();
        wdesc(2, mkword(8, 1, 1, 0, 0));
        wdesc(3, mkword(4, 1, 1, 0, 0));
        setlp(4);
        tick();
        ctl_enable = 1'b0;
        @(negedge clk);
        check(st_state == 2'd1, "R8 active until boundary", int'(st_state), 1);
        rdy_force = 1'b1;
        wait_state(2'd0, 50, "R8 disabled after boundary");
        repeat (4) @(negedge clk);
        check(st_cur_idx == 3 && !rq_valid, "R8 no fetch while disabled", int'(st_cur_idx), 3);
        #2 ctl_enable = 1'b1;
        wait_state(2'd2, 50, "R8 re-enable drains");

        // R5 / R11 / R6: zero-length descriptor, then end-of-table wrap
        tick();
        b0 = beats_seen;
        wdesc(4, mkword(0, 1, 1, 1, 0));
        wdesc(5, mkword(3, 1, 1, 1, 1));
        setlp(0);
        wait_state(2'd2, 50, "R4 wrap drain");
        check(st_cur_idx == 0, "R5 end-of-table wraps", int'(st_cur_idx), 0);
        check(beats_seen - b0 == 1, "R11 zero count has no beat", beats_seen - b0, 1);
        repeat (2) @(negedge clk);
        check(done_seen == exp_done, "R6 completion pulses", done_seen, exp_done);

        // R10: loopback mark follows the descriptor
        tick();
        ctl_loop = 1'b1;
        b0 = loop_beats;
        wdesc(0, mkword(6, 1, 1, 0, 0));
        setlp(1);
        wait_state(2'd2, 50, "R10 drain");
        check(loop_beats - b0 == 2, "R10 loop beats", loop_beats - b0, 2);
        #2 ctl_loop = 1'b0;

        // Random batches with back-pressure, suspend toggles, pointer moves
        rdy_mode = 1;
        for (int bt = 0; bt < 12; bt++) begin
            int k1 = 1 + int'($urandom % 3);
            int k2 = 1 + int'($urandom % 4);
            logic [IW-1:0] p = mcur;
            tick();
            for (int i = 0; i < k1; i++) begin
                wdesc(p, mkword(int'($urandom % 24), $urandom % 2, $urandom % 2, $urandom % 2, 0));
                p = p + IW'(1);
            end
            setlp(p);
            for (int i = 0; i < k2; i++) begin
                wdesc(p, mkword(int'($urandom % 24), $urandom % 2, $urandom % 2, $urandom % 2, 0));
                ctl_suspend = (($urandom % 5) == 0);
                p = p + IW'(1);
            end
            setlp(p);
            for (int c = 0; c < 30; c++) begin
                ctl_suspend = (($urandom % 4) == 0);
                tick();
            end
            ctl_suspend = 1'b0;
            wait_state(2'd2, 600, "R4 batch drained");
            check(st_cur_idx == p, "R4 index reaches pointer", int'(st_cur_idx), int'(p));
        end
        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R2 all beats delivered", expq.size(), 0);
        check(done_seen == exp_done, "R6 total completions", done_seen, exp_done);
        finish_run();
    end
endmodule